// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block holds up to eight memory operations in program order and decides, every cycle, which of them may be sent to the memory system ahead of older operations that are still outstanding. It applies a write-ordered model in which loads can bypass stores. Loads keep their order, and stores keep their order with each other and with older loads. A load may overtake an older store only when the two target different cache lines. A same-line load is released with a flag that tells the load unit to take its data from the youngest matching older store. Line flushes come in a strict and a relaxed flavour. Load, store and full fences each apply their own scope. Locked, I/O and serializing operations act as complete barriers.

An upstream dispatcher writes one operation per cycle through the enqueue port. The memory pipeline reads the per-slot eligibility and forwarding outputs and reports each finished slot on the completion vector. A completed slot leaves the queue at the next clock edge. The survivors move down toward slot 0 and keep their relative order, so the slot number always gives relative age. Cache-line identity is taken from the address bits above the low six, which gives 64-byte lines.

Top module: `mem_order_queue`

## Requirements
- R1: An operation is written when `enqValid` is high and `enqReady` is high. It appears in the lowest free slot after the next clock edge. `enqReady` is low exactly when all eight slots are occupied, and a write offered while full is dropped. Operation codes are: 0 load, 1 store, 2 non-temporal store, 3 strict flush, 4 relaxed flush, 5 load fence, 6 store fence, 7 full fence, 8 locked/I/O/serializing. Codes 9 to 15 are treated as code 8.
- R2: Setting bit k of `compDone` removes occupied slot k at the next edge. The remaining operations move down with their order unchanged. Bits for empty slots have no effect.
- R3: After reset the queue is empty and `enqReady` is high. An empty slot is never eligible, and an occupied slot 0 is always eligible.
- R4: A load waits for every older load. A store of either kind also waits for every older load.
- R5: An ordinary store waits for older ordinary stores. A non-temporal store does not wait for older stores, and an ordinary store does not wait for an older non-temporal store.
- R6: Two addresses are on the same line when bits 31:6 are equal. A load is not held back by older stores of either kind. If an older store is on the same line and the load is eligible, `fwdFlag` is set for the load's slot, and its 3-bit field of `fwdSrc` (bits 3k+2:3k for slot k) holds the slot of the youngest such store.
- R7: A strict flush waits for all older stores of both kinds and all older strict flushes. Younger stores and strict flushes wait for it.
- R8: A relaxed flush waits for older stores and flushes only when they are on the same line. Likewise, younger stores and flushes wait for an older relaxed flush only when on the same line. Loads and flushes never order against each other.
- R9: A serializing operation is eligible only with no older operation in the queue, and no younger operation is eligible while it is present.
- R10: A load fence waits only for older loads. Every younger load, store and flush waits for it.
- R11: A store fence waits for older stores and flushes but not loads. Younger stores and flushes wait for it, and younger loads do not.
- R12: A full fence waits for every older load, store and flush. Every younger load, store and flush waits for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| enqValid | input | 1 | Offer an operation for enqueue |
| enqType | input | 4 | Operation code (see R1) |
| enqAddr | input | 32 | Byte address; bits 31:6 select the line |
| enqReady | output | 1 | Queue has a free slot |
| compDone | input | 8 | Per-slot completion, removes the slot |
| entValid | output | 8 | Per-slot occupancy, slot 0 oldest |
| issueOk | output | 8 | Per-slot issue eligibility |
| fwdFlag | output | 8 | Eligible load must take forwarded store data |
| fwdSrc | output | 24 | Per-slot 3-bit slot index of the forwarding store |

## Verification
Directed sequences of two to five operations put each ordering rule into a pair where it alone decides eligibility. Each such pair is matched with a twin that differs only in line address or in the store flavour. This separates a line-sensitive rule from a blanket one, and an ordinary store from a non-temporal one. The forwarding sequence places two same-line stores with a different-line store between them, so a forward source that is not the youngest match is exposed. Retirement from the head, from the middle and from an empty slot, together with a write offered while full, shows whether compaction keeps age order. A long random stream over three lines, with random offsets inside each line, then compares every slot's eligibility and forwarding against an independent pairwise model as operations complete out of order.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;

  typedef enum logic [3:0] {
    OP_LD    = 4'd0,
    OP_ST    = 4'd1,
    OP_NTST  = 4'd2,
    OP_FLSTR = 4'd3,
    OP_FLREL = 4'd4,
    OP_LFEN  = 4'd5,
    OP_SFEN  = 4'd6,
    OP_MFEN  = 4'd7,
    OP_SER   = 4'd8
  } opKindE;

  // strobes from control to datapath
  typedef struct packed {
    logic push;   // append the offered operation
    logic shift;  // at least one slot retires
  } ctlStrobeT;

  // true when a younger operation must stay behind an older pending one
  function automatic logic mustWait(opKindE older, opKindE younger, logic sameLine);
    if (older == OP_SER || younger == OP_SER) return 1'b1;
    case (younger)
      OP_LD:    return older inside {OP_LD, OP_LFEN, OP_MFEN};
      OP_ST:    return (older inside {OP_LD, OP_ST, OP_FLSTR, OP_LFEN, OP_SFEN, OP_MFEN})
                       || (older == OP_FLREL && sameLine);
      OP_NTST:  return (older inside {OP_LD, OP_FLSTR, OP_LFEN, OP_SFEN, OP_MFEN})
                       || (older == OP_FLREL && sameLine);
      OP_FLSTR: return (older inside {OP_ST, OP_NTST, OP_FLSTR, OP_LFEN, OP_SFEN, OP_MFEN})
                       || (older == OP_FLREL && sameLine);
      OP_FLREL: return (older inside {OP_LFEN, OP_SFEN, OP_MFEN})
                       || ((older inside {OP_ST, OP_NTST, OP_FLSTR, OP_FLREL}) && sameLine);
      OP_LFEN:  return older == OP_LD;
      OP_SFEN:  return older inside {OP_ST, OP_NTST, OP_FLSTR, OP_FLREL};
      OP_MFEN:  return older inside {OP_LD, OP_ST, OP_NTST, OP_FLSTR, OP_FLREL};
      default:  return 1'b1;
    endcase
  endfunction

  function automatic logic isStore(opKindE k);
    return k == OP_ST || k == OP_NTST;
  endfunction

endpackage

// File: rtl/mem_order_dp.sv
module mem_order_dp
  import mem_order_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobeT                     strb,
  input  logic [DEPTH-1:0]              keepMask,
  input  logic [3:0]                    enqKind,
  input  logic [ADDR_W-LINE_BITS-1:0]   enqLine,
  output logic [DEPTH-1:0]              entVld,
  output opKindE                        entKind [DEPTH],
  output logic [ADDR_W-LINE_BITS-1:0]   entLine [DEPTH]
);

  localparam int LINE_W = ADDR_W - LINE_BITS;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  vldQ, nVld;
  opKindE            kindQ [DEPTH];
  opKindE            nKind [DEPTH];
  logic [LINE_W-1:0] lineQ [DEPTH];
  logic [LINE_W-1:0] nLine [DEPTH];
  opKindE            normKind;

  // unknown codes are held as full barriers
  assign normKind = (enqKind > 4'd8) ? OP_SER : opKindE'(enqKind);

  // compaction: survivors slide toward slot 0 in age order, new entry appended
  always_comb begin
    logic [CNT_W-1:0] slot;
    nVld = '0;
    for (int k = 0; k < DEPTH; k++) begin
      nKind[k] = OP_LD;
      nLine[k] = '0;
    end
    slot = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (keepMask[j]) begin
        nVld[slot[IDX_W-1:0]]  = 1'b1;
        nKind[slot[IDX_W-1:0]] = kindQ[j];
        nLine[slot[IDX_W-1:0]] = lineQ[j];
        slot = slot + 1'b1;
      end
    end
    if (strb.push && slot < CNT_W'(DEPTH)) begin
      nVld[slot[IDX_W-1:0]]  = 1'b1;
      nKind[slot[IDX_W-1:0]] = normKind;
      nLine[slot[IDX_W-1:0]] = enqLine;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        kindQ[k] <= OP_LD;
        lineQ[k] <= '0;
      end
    end else if (strb.push || strb.shift) begin
      vldQ <= nVld;
      for (int k = 0; k < DEPTH; k++) begin
        kindQ[k] <= nKind[k];
        lineQ[k] <= nLine[k];
      end
    end
  end

  assign entVld = vldQ;
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      entKind[k] = kindQ[k];
      entLine[k] = lineQ[k];
    end
  end

endmodule

// File: rtl/mem_order_ctl.sv
module mem_order_ctl
  import mem_order_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26
) (
  input  logic                      enqValid,
  input  logic [DEPTH-1:0]          compDone,
  input  logic [DEPTH-1:0]          entVld,
  input  opKindE                    entKind [DEPTH],
  input  logic [LINE_W-1:0]         entLine [DEPTH],
  output ctlStrobeT                 strb,
  output logic [DEPTH-1:0]          keepMask,
  output logic                      enqReady,
  output logic [DEPTH-1:0]          issueOk,
  output logic [DEPTH-1:0]          fwdFlag,
  output logic [DEPTH*$clog2(DEPTH)-1:0] fwdSrc
);

  localparam int IDX_W = $clog2(DEPTH);

  assign enqReady   = !(&entVld);
  assign keepMask   = entVld & ~compDone;
  assign strb.push  = enqValid && enqReady;
  assign strb.shift = |(entVld & compDone);

  // pairwise check of each slot against every older occupied slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             blk;
    logic             hit;
    logic [IDX_W-1:0] src;

    always_comb begin
      blk = 1'b0;
      hit = 1'b0;
      src = '0;
      for (int j = 0; j < i; j++) begin
        if (entVld[j]) begin
          if (mustWait(entKind[j], entKind[i], entLine[j] == entLine[i])) blk = 1'b1;
          if (entKind[i] == OP_LD && isStore(entKind[j]) && entLine[j] == entLine[i]) begin
            hit = 1'b1;
            src = IDX_W'(j);   // ascending scan leaves the youngest match
          end
        end
      end
    end

    assign issueOk[i]               = entVld[i] && !blk;
    assign fwdFlag[i]               = entVld[i] && !blk && hit;
    assign fwdSrc[i*IDX_W +: IDX_W] = src;
  end

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import mem_order_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enqValid,
  input  logic [3:0]                    enqType,
  input  logic [ADDR_W-1:0]             enqAddr,
  output logic                          enqReady,
  input  logic [DEPTH-1:0]              compDone,
  output logic [DEPTH-1:0]              entValid,
  output logic [DEPTH-1:0]              issueOk,
  output logic [DEPTH-1:0]              fwdFlag,
  output logic [DEPTH*$clog2(DEPTH)-1:0] fwdSrc
);

  localparam int LINE_W = ADDR_W - LINE_BITS;

  ctlStrobeT         strb;
  logic [DEPTH-1:0]  keepMask;
  opKindE            entKind [DEPTH];
  logic [LINE_W-1:0] entLine [DEPTH];
  logic [DEPTH*4-1:0] entKindFlat;
  logic              unusedOffset;

  assign unusedOffset = ^enqAddr[LINE_BITS-1:0];

  for (genvar k = 0; k < DEPTH; k++) begin : g_flat
    assign entKindFlat[k*4 +: 4] = entKind[k];
  end

  mem_order_dp #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .keepMask (keepMask),
    .enqKind  (enqType),
    .enqLine  (enqAddr[ADDR_W-1:LINE_BITS]),
    .entVld   (entValid),
    .entKind  (entKind),
    .entLine  (entLine)
  );

  mem_order_ctl #(
    .DEPTH(DEPTH), .LINE_W(LINE_W)
  ) u_ctl (
    .enqValid (enqValid),
    .compDone (compDone),
    .entVld   (entValid),
    .entKind  (entKind),
    .entLine  (entLine),
    .strb     (strb),
    .keepMask (keepMask),
    .enqReady (enqReady),
    .issueOk  (issueOk),
    .fwdFlag  (fwdFlag),
    .fwdSrc   (fwdSrc)
  );

endmodule

// File: rtl/mem_order_queue_chk.sv
module mem_order_queue_chk #(
  parameter int DEPTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               enqValid,
  input logic               enqReady,
  input logic [DEPTH-1:0]   compDone,
  input logic [DEPTH-1:0]   entValid,
  input logic [DEPTH-1:0]   issueOk,
  input logic [DEPTH-1:0]   fwdFlag,
  input logic [DEPTH*4-1:0] entKindFlat
);

  logic [DEPTH-1:0] isSer;
  logic [DEPTH-1:0] olderSer;
  logic             unusedHeadSer;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      isSer[k]    = entValid[k] && (entKindFlat[k*4 +: 4] == 4'd8);
      olderSer[k] = acc;
      acc         = acc | isSer[k];
    end
  end
  assign unusedHeadSer = olderSer[0];

  // R3
  head_elig_chk: assert property (@(posedge clk) disable iff (!rstN)
    entValid[0] |-> issueOk[0]);

  // R3
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueOk & ~entValid) == '0);

  // R1
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&entValid) |-> !enqReady);

  // R1
  push_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enqValid && enqReady && compDone == '0) |=>
      $countones(entValid) == $past($countones(entValid)) + 1);

  // R2
  fill_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((entValid + DEPTH'(1)) & entValid) == '0);

  // R6
  fwd_elig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdFlag & ~issueOk) == '0);

  for (genvar i = 1; i < DEPTH; i++) begin : g_ser
    // R9
    ser_block_chk: assert property (@(posedge clk) disable iff (!rstN)
      issueOk[i] |-> !olderSer[i]);
    // R9
    ser_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(issueOk[i] && isSer[i]));
  end

endmodule

bind mem_order_queue mem_order_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enqValid    (enqValid),
  .enqReady    (enqReady),
  .compDone    (compDone),
  .entValid    (entValid),
  .issueOk     (issueOk),
  .fwdFlag     (fwdFlag),
  .entKindFlat (entKindFlat)
);

// File: tb/mem_order_queue_bench.sv
module mem_order_queue_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int IDX_W      = 3;

  localparam logic [3:0] LD = 4'd0, ST = 4'd1, NT = 4'd2, FS = 4'd3, FR = 4'd4,
                         LF = 4'd5, SF = 4'd6, MF = 4'd7, SR = 4'd8;
  localparam logic [31:0] A = 32'h1000, B = 32'h2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enqValid = 1'b0;
  logic [3:0] enqType = '0;
  logic [31:0] enqAddr = '0;
  logic enqReady;
  logic [DEPTH-1:0] compDone = '0;
  logic [DEPTH-1:0] entValid, issueOk, fwdFlag;
  logic [DEPTH*IDX_W-1:0] fwdSrc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_order_queue u_mem_order_queue (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqType(enqType), .enqAddr(enqAddr),
    .enqReady(enqReady), .compDone(compDone), .entValid(entValid), .issueOk(issueOk),
    .fwdFlag(fwdFlag), .fwdSrc(fwdSrc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic resetDut();
    rstN = 1'b0; enqValid = 1'b0; compDone = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic push(input logic [3:0] t, input logic [31:0] a);
    enqValid = 1'b1; enqType = t; enqAddr = a;
    @(negedge clk);
    enqValid = 1'b0; #1;
  endtask

  task automatic complete(input logic [DEPTH-1:0] m);
    compDone = m;
    @(negedge clk);
    compDone = '0; #1;
  endtask

  task automatic pair(input string req, input logic [3:0] t0, input logic [31:0] a0,
                      input logic [3:0] t1, input logic [31:0] a1, input logic [7:0] exp);
    resetDut();
    push(t0, a0);
    push(t1, a1);
    chk(req, issueOk, exp);
  endtask

  task automatic testReset();
    resetDut();
    chk("R3 reset valid", entValid, 0);
    chk("R3 reset issue", issueOk, 0);
    chk("R3 reset ready", enqReady, 1);
  endtask

  task automatic testLoads();
    pair("R4 load after load", LD, A, LD, B, 8'h01);
    pair("R4 store after load", LD, A, ST, B, 8'h01);
    pair("R4 nt store after load", LD, A, NT, B, 8'h01);
  endtask

  task automatic testStores();
    pair("R5 store after store", ST, A, ST, B, 8'h01);
    pair("R5 nt store after store", ST, A, NT, B, 8'h03);
    pair("R5 store after nt store", NT, A, ST, B, 8'h03);
  endtask

  task automatic testForward();
    pair("R6 load passes other-line store", ST, A, LD, B, 8'h03);
    chk("R6 no forward other line", fwdFlag, 0);
    resetDut();
    push(ST, 32'h1000); push(ST, 32'h2000); push(ST, 32'h1010); push(LD, 32'h103F);
    chk("R6 forward issue", issueOk, 8'h09);
    chk("R6 forward flag", fwdFlag, 8'h08);
    chk("R6 youngest source", fwdSrc[3*IDX_W +: IDX_W], 2);
    push(LD, 32'h1040);
    chk("R6 line boundary load waits older load", issueOk, 8'h09);
    chk("R6 line boundary no forward", fwdFlag, 8'h08);
  endtask

  task automatic testStrict();
    pair("R7 strict after store", ST, A, FS, B, 8'h01);
    pair("R7 strict after nt store", NT, A, FS, B, 8'h01);
    pair("R7 strict after strict", FS, A, FS, B, 8'h01);
    pair("R7 store after strict", FS, A, ST, B, 8'h01);
    pair("R8 strict after load", LD, A, FS, B, 8'h03);
  endtask

  task automatic testRelaxed();
    pair("R8 relaxed other line", ST, A, FR, B, 8'h03);
    pair("R8 relaxed same line", ST, A, FR, 32'h1020, 8'h01);
    pair("R8 relaxed after strict other line", FS, A, FR, B, 8'h03);
    pair("R8 relaxed pair other line", FR, A, FR, B, 8'h03);
    pair("R8 store after relaxed same line", FR, A, ST, 32'h1008, 8'h01);
    pair("R8 load after relaxed", FR, A, LD, A, 8'h03);
  endtask

  task automatic testSerial();
    resetDut();
    push(LD, A); push(SR, A); push(LD, B);
    chk("R9 barrier between loads", issueOk, 8'h01);
    pair("R9 barrier after flush", FR, A, SR, B, 8'h01);
    pair("R9 fence after barrier", SR, A, SF, B, 8'h01);
    pair("R1 R9 unknown code acts as barrier", 4'd12, A, NT, B, 8'h01);
  endtask

  task automatic testFences();
    resetDut();
    push(ST, A); push(LF, A); push(LD, B);
    chk("R10 load fence ignores store, holds load", issueOk, 8'h03);
    pair("R10 load fence after load", LD, A, LF, B, 8'h01);
    pair("R10 nt store after load fence", LF, A, NT, B, 8'h01);
    resetDut();
    push(ST, A); push(SF, A); push(LD, B);
    chk("R11 store fence waits store, load passes", issueOk, 8'h05);
    pair("R11 store fence after relaxed flush", FR, A, SF, B, 8'h01);
    pair("R11 relaxed flush after store fence", SF, A, FR, B, 8'h01);
    pair("R11 store fence after load", LD, A, SF, B, 8'h03);
    pair("R12 full fence after load", LD, A, MF, B, 8'h01);
    pair("R12 load after full fence", MF, A, LD, B, 8'h01);
    pair("R12 full fence after strict flush", FS, A, MF, B, 8'h01);
    pair("R12 full fence after nt store", NT, A, MF, B, 8'h01);
  endtask

  task automatic testRetire();
    resetDut();
    push(LD, A); push(ST, B); push(LD, 32'h3000);
    chk("R2 before retire", issueOk, 8'h01);
    complete(8'h01);
    chk("R2 head retire valid", entValid, 8'h03);
    chk("R2 head retire issue", issueOk, 8'h03);
    complete(8'h80);
    chk("R2 empty slot completion ignored", entValid, 8'h03);
    complete(8'h02);
    chk("R2 middle retire valid", entValid, 8'h01);
    push(LD, B);
    chk("R2 store kept at head", fwdFlag, 8'h02);
    chk("R2 forward source slot", fwdSrc[1*IDX_W +: IDX_W], 0);
  endtask

  task automatic testFull();
    resetDut();
    for (int k = 0; k < DEPTH; k++) push(NT, 32'h40 * k);
    chk("R1 full valid", entValid, 8'hFF);
    chk("R1 full ready low", enqReady, 0);
    chk("R5 nt stores all eligible", issueOk, 8'hFF);
    push(LD, A);
    chk("R1 write while full dropped", entValid, 8'hFF);
    complete(8'h01);
    chk("R1 dropped write absent", entValid, 8'h7F);
    chk("R1 ready again", enqReady, 1);
  endtask

  function automatic bit modelWait(int o, int y, bit same);
    if (o == 8 || y == 8) return 1;
    case (o)
      0: return y inside {0, 1, 2, 5, 7};
      1: return (y inside {1, 3, 6, 7}) || (y == 4 && same);
      2: return (y inside {3, 6, 7}) || (y == 4 && same);
      3: return (y inside {1, 2, 3, 6, 7}) || (y == 4 && same);
      4: return (y inside {6, 7}) || ((y inside {1, 2, 3, 4}) && same);
      5: return y inside {0, 1, 2, 3, 4};
      6: return y inside {1, 2, 3, 4};
      7: return y inside {0, 1, 2, 3, 4};
      default: return 1;
    endcase
  endfunction

  task automatic testRandom();
    int mKind [DEPTH];
    logic [25:0] mLine [DEPTH];
    int mCnt;
    resetDut();
    mCnt = 0;
    for (int c = 0; c < 3000; c++) begin
      logic [7:0] expIss, expFwd, doneM;
      logic [3:0] t;
      logic [31:0] a;
      bit doPush;
      int nCnt;
      int nKind [DEPTH];
      logic [25:0] nLine [DEPTH];
      expIss = '0; expFwd = '0;
      for (int i = 0; i < mCnt; i++) begin
        bit blk, hit;
        int src;
        blk = 0; hit = 0; src = 0;
        for (int j = 0; j < i; j++) begin
          if (modelWait(mKind[j], mKind[i], mLine[j] == mLine[i])) blk = 1;
          if (mKind[i] == 0 && (mKind[j] == 1 || mKind[j] == 2) && mLine[j] == mLine[i]) begin
            hit = 1; src = j;
          end
        end
        expIss[i] = !blk;
        expFwd[i] = !blk && hit;
        if (!blk && hit && fwdFlag[i])
          chk("R6 random forward source", fwdSrc[i*IDX_W +: IDX_W], src);
      end
      chk("random eligibility R4 R5 R7 R8 R9 R10 R11 R12", issueOk, expIss);
      chk("random forwarding R6", fwdFlag, expFwd);
      doneM = issueOk & 8'($urandom);
      doPush = (mCnt < DEPTH) && ($urandom % 3 != 0);
      t = 4'($urandom % 10);
      a = (($urandom % 3) + 1) * 64 + ($urandom % 64);
      compDone = doneM; enqValid = doPush; enqType = t; enqAddr = a;
      @(negedge clk); #1;
      nCnt = 0;
      for (int k = 0; k < DEPTH; k++) begin nKind[k] = 0; nLine[k] = '0; end
      for (int k = 0; k < mCnt; k++)
        if (!doneM[k]) begin nKind[nCnt] = mKind[k]; nLine[nCnt] = mLine[k]; nCnt++; end
      if (doPush) begin
        nKind[nCnt] = (t > 8) ? 8 : int'(t);
        nLine[nCnt] = a[31:6];
        nCnt++;
      end
      mCnt = nCnt;
      for (int k = 0; k < DEPTH; k++) begin mKind[k] = nKind[k]; mLine[k] = nLine[k]; end
    end
    compDone = '0; enqValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R3 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testLoads();
    testStores();
    testForward();
    testStrict();
    testRelaxed();
    testSerial();
    testFences();
    testRetire();
    testFull();
    testRandom();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule